// File: doc/BRIEF.md
# Reloadable Baud Rate Counter

This block divides a clock down to serial bit-rate ticks. A down-counter steps once per source event. When it reaches zero it reloads from a programmable 15-bit division value and emits a one-cycle tick, so the tick period is the division value plus one source events. The source is either every cycle of the block clock, or each synchronized rising edge of an external clock input.

Software programs the block through a 16-bit configuration word. The top bit selects the external source and the lower fifteen bits hold the division value. The word changes only on a full-width write. A new division value does not disturb the count in progress; it takes effect at the next reload. A separate clear strobe reloads the counter at once from the current value, or from a value written in the same cycle.

Top module: `baud_reload_counter`

## Requirements
- R1: While `rst_n` is low, `tick` is 0 and the configuration word and count are 0. After reset, with internal source and division 0, `tick` is high on every cycle.
- R2: A write with both `wr_en` and `wr_full` high stores `wr_data`. Bit 15 is the source select (1 = external) and bits 14:0 are the division value D.
- R3: A write with `wr_en` high and `wr_full` low changes neither the select bit nor D. This is observed through the tick period that follows.
- R4: With internal source, `tick` is high for exactly one cycle per D+1 clock cycles. When D is 0, `tick` stays high.
- R5: A new D written while a count is in progress does not alter that count. The next tick comes on schedule for the old count, and the ticks after it are spaced D_new+1 cycles apart.
- R6: A `clr` pulse loads D into the counter at that clock edge without emitting a tick. The first tick then appears D+1 cycles after the clear edge.
- R7: When `clr` falls on the edge at which the count would reload from zero, the clear wins and no tick is emitted at that edge.
- R8: When `clr` and a full write fall on the same edge, the counter loads the newly written D.
- R9: With external source, the counter steps once per rising edge of `ext_clk`, after a two-flip-flop synchronizer. It does not step while `ext_clk` is steady, so N rising edges after a clear give N/(D+1) ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk | input | 1 | Asynchronous external count source |
| wr_en | input | 1 | Configuration write strobe |
| wr_full | input | 1 | Marks the write as a full 16-bit access |
| wr_data | input | 16 | Configuration word: bit 15 source select, bits 14:0 division value |
| clr | input | 1 | Immediate reload command |
| tick | output | 1 | One-cycle pulse at each reload from zero |

## Verification
The clear command and the natural reload from zero can meet on one clock edge. The bench provokes this by counting cycles from a known clear and raising `clr` exactly on the cycle in which the count holds zero. The judgement is that no tick appears at that edge and that the next tick arrives a full D+1 cycles later. The bench also lands a full write on the same edge as a clear, and checks that the first tick position follows the written value rather than the old one.

// File: rtl/baud_reload_counter.sv
module baud_reload_counter #(
  parameter int DIV_W       = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             wr_en,
  input  logic             wr_full,
  input  logic [DIV_W:0]   wr_data,
  input  logic             clr,
  output logic             tick
);

  logic             ext_sel;
  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] count;
  logic [SYNC_STAGES:0] ext_sync;

  wire wr_ok = wr_en & wr_full;
  wire [DIV_W-1:0] load_val = wr_ok ? wr_data[DIV_W-1:0] : div;
  wire ext_rise = ext_sync[SYNC_STAGES-1] & ~ext_sync[SYNC_STAGES];
  wire step     = ext_sel ? ext_rise : 1'b1;
  wire at_zero  = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[SYNC_STAGES-1:0], ext_clk};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_sel <= 1'b0;
      div     <= '0;
    end else if (wr_ok) begin
      ext_sel <= wr_data[DIV_W];
      div     <= wr_data[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (clr)     count <= load_val;
    else if (step)    count <= at_zero ? div : count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~clr & step & at_zero;
  end

endmodule

module baud_reload_checks #(
  parameter int DIV_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_full,
  input logic [DIV_W:0]   wr_data,
  input logic             clr,
  input logic             tick,
  input logic             ext_sel,
  input logic [DIV_W-1:0] div,
  input logic [DIV_W-1:0] count
);

  a_r2_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_full) |=> ({ext_sel, div} == $past(wr_data)));

  a_r3_narrow_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_full) |=> ({ext_sel, div} == $past({ext_sel, div})));

  a_r4_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != '0) |=> !tick);

  a_r4_internal_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && !clr && count != '0) |=> (count == $past(count) - 1'b1));

  a_r5_tick_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && count == '0 && !ext_sel) |=> (tick && count == $past(div)));

  a_r6_clear_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(wr_en && wr_full)) |=> (count == $past(div) && !tick));

  a_r8_clear_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && wr_en && wr_full) |=> (count == $past(wr_data[DIV_W-1:0])));

  a_r9_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && !clr && count != '0 && $past(ext_sel) && $past(!clr)
     && $past(count) == count) |=> (count == $past(count) || count == $past(count) - 1'b1));

endmodule

bind baud_reload_counter baud_reload_checks #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_full(wr_full), .wr_data(wr_data),
  .clr(clr), .tick(tick), .ext_sel(ext_sel), .div(div), .count(count)
);

// File: tb/test_baud_reload_counter.sv
`timescale 1ns/1ps
module test_baud_reload_counter;

  logic clk = 0, rst_n = 0, ext_clk = 0, wr_en = 0, wr_full = 0, clr = 0;
  logic [15:0] wr_data = '0;
  logic tick;
  int n_pass = 0, n_tot = 0, tick_cnt = 0;
  bit mon_en = 0;

  always #10 clk = ~clk;

  baud_reload_counter i_baud_reload_counter (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .wr_en(wr_en), .wr_full(wr_full),
    .wr_data(wr_data), .clr(clr), .tick(tick)
  );

  always @(negedge clk) if (mon_en && tick) tick_cnt++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tot++;
    if (ok) n_pass++;
    else $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
  endtask

  task automatic wr(input logic [15:0] d, input bit full);
    wr_en = 1; wr_full = full; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_full = 0;
  endtask

  task automatic clear_pulse();
    clr = 1;
    @(negedge clk);
    clr = 0;
  endtask

  task automatic ext_rises(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1; repeat (4) @(negedge clk);
      ext_clk = 0; repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_tot++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_pass, n_tot);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tick == 0, "R1 reset tick", tick, 0);
    rst_n = 1;
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk);
      check(tick == 1, "R1 div0 after reset", tick, 1);
    end

    // R2 R4 R6: sweep internal division values
    for (int d = 0; d <= 12; d++) begin
      wr(16'(d), 1);
      clear_pulse();
      for (int j = 1; j <= 2*d + 2; j++) begin
        @(negedge clk);
        check(tick == ((j == d+1) || (j == 2*d+2)), "R4 R6 period", tick,
              int'((j == d+1) || (j == 2*d+2)));
      end
    end

    // R5: deferred reload
    wr(16'd5, 1);
    clear_pulse();
    repeat (2) @(negedge clk);
    wr(16'd2, 1);
    for (int j = 4; j <= 12; j++) begin
      @(negedge clk);
      check(tick == ((j == 6) || (j == 9) || (j == 12)), "R5 deferred", tick,
            int'((j == 6) || (j == 9) || (j == 12)));
    end

    // R3: narrow write ignored
    wr(16'd3, 1);
    clear_pulse();
    wr(16'h8007, 0);
    clear_pulse();
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      check(tick == ((j == 4) || (j == 8)), "R3 narrow ignored", tick,
            int'((j == 4) || (j == 8)));
    end

    // R7: clear on the reload edge
    wr(16'd4, 1);
    clear_pulse();
    repeat (4) @(negedge clk);
    clear_pulse();
    check(tick == 0, "R7 clear wins", tick, 0);
    for (int j = 1; j <= 5; j++) begin
      @(negedge clk);
      check(tick == (j == 5), "R7 after clear", tick, int'(j == 5));
    end

    // R8: clear and write on one edge
    wr_en = 1; wr_full = 1; wr_data = 16'd2; clr = 1;
    @(negedge clk);
    wr_en = 0; wr_full = 0; clr = 0;
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      check(tick == ((j == 3) || (j == 6)), "R8 clear with write", tick,
            int'((j == 3) || (j == 6)));
    end

    // R9: external source
    wr(16'h8002, 1);
    repeat (4) @(negedge clk);
    clear_pulse();
    tick_cnt = 0; mon_en = 1;
    repeat (30) @(negedge clk);
    check(tick_cnt == 0, "R9 steady ext", tick_cnt, 0);
    ext_rises(9);
    check(tick_cnt == 3, "R9 ext D2", tick_cnt, 3);
    mon_en = 0;
    wr(16'h8000, 1);
    clear_pulse();
    tick_cnt = 0; mon_en = 1;
    ext_rises(5);
    check(tick_cnt == 5, "R9 ext D0", tick_cnt, 5);
    mon_en = 0;

    $display("%0d/%0d checks passed", n_pass, n_tot);
    $finish;
  end

endmodule